// File: doc/BRIEF.md
# CAN frame field parser

This block sits behind a CAN bit sampler and destuffer. Each destuffed frame bit arrives with a valid strobe and its index in the frame, counted from 0 at start of frame. The parser turns that stream into decoded fields. It reports the identifier in base form (11 bits) or extended form (29 bits), the frame-format flags, the data length code, the data bytes, the received CRC field and the acknowledge status. It also marks the end of each frame and any form violation with a pulse.

The field boundaries are not fixed. The identifier-extension bit at index 13 chooses between two header layouts. The data length code, together with the remote flag, then sets how many data bits follow. The CRC sequence, the delimiters, the acknowledge slot and the end-of-frame bits are found as offsets from the last data bit. Computing the CRC, handling error and overload frames, and driving the acknowledge bit are the job of neighbouring blocks.

Top module: `can_field_parser`

## Requirements
- R1: Index 0 opens a frame when it is dominant (0). A recessive (1) bit at index 0 gives a one-cycle `form_err_o` pulse, and no frame is opened.
- R2: Indexes 1 to 11 carry the base identifier, most significant bit first. In a base frame, `id_o` holds that value, zero-extended to 29 bits.
- R3: Index 13 selects the frame format: 0 means base and 1 means extended. It is reported on `ide_o`. In a base frame, `rtr_o` takes the value of index 12 and `srr_o` is 0.
- R4: In an extended frame, indexes 14 to 31 carry an 18-bit extension, most significant bit first. `id_o` = (base identifier << 18) | extension. `srr_o` takes the value of index 12, and `rtr_o` takes the value of index 32.
- R5: The 4-bit length code is read MSB first, from indexes 15 to 18 in a base frame and from indexes 35 to 38 in an extended frame. The header outputs update together with a one-cycle `hdr_stb_o` pulse, which is issued once per frame. Reserved bits (index 14 in a base frame, indexes 33 and 34 in an extended frame) are accepted at either level.
- R6: Data bytes start right after the length code and arrive MSB first. Each complete byte is shown on `byte_o` with a `byte_stb_o` pulse and its position (0 first) on `byte_num_o`. The byte count is the length code, capped at 8.
- R7: When `rtr_o` is 1 (remote frame) there are no data bytes and no `byte_stb_o` pulse. The CRC field begins right after the length code.
- R8: The 15 bits after the last data bit are the CRC sequence, MSB first. They appear on `crc_o` with a one-cycle `crc_stb_o` pulse.
- R9: The bit at offset 17 past the last data bit is the acknowledge slot. `ack_o` is set to 1 when that bit is dominant and to 0 when it is recessive, and it holds that value until the next slot.
- R10: If the bits at offsets 16 (CRC delimiter), 18 (acknowledge delimiter) and 19 to 25 (end of frame) are all recessive, offset 25 gives a one-cycle `eof_o` pulse, and the frame closes.
- R11: A dominant bit at any of the offsets 16, 18 or 19 to 25 gives a `form_err_o` pulse in place of `eof_o` and aborts the frame. Any later bits with a nonzero index are ignored.
- R12: Every output changes on the clock edge after the bit that causes it. Cycles with `bit_valid_i` low have no effect. Bits with a nonzero index that arrive while no frame is open have no effect. A new index-0 bit restarts parsing at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | A destuffed frame bit is present |
| bit_idx_i | input | IDX_W | Index of the bit within the frame, 0 = start of frame |
| bit_val_i | input | 1 | Bit level, 0 = dominant |
| hdr_stb_o | output | 1 | Header outputs updated |
| id_o | output | 29 | Base or full extended identifier |
| ide_o | output | 1 | Extended format flag |
| rtr_o | output | 1 | Remote frame flag |
| srr_o | output | 1 | Index 12 value in an extended frame |
| dlc_o | output | 4 | Received length code |
| byte_o | output | 8 | Data byte |
| byte_stb_o | output | 1 | Data byte valid |
| byte_num_o | output | 3 | Position of the data byte |
| crc_o | output | 15 | Received CRC sequence |
| crc_stb_o | output | 1 | CRC sequence valid |
| ack_o | output | 1 | Last acknowledge slot was dominant |
| eof_o | output | 1 | Frame ended correctly |
| form_err_o | output | 1 | Form violation seen |

## Verification
The assertions assume that within a frame the indexes arrive one per valid strobe, in strictly increasing order and without gaps, starting from index 0. Remote-frame and byte-count checks depend on this, because a skipped index would never match a field boundary. The stimulus respects this by building each frame as a complete bit list and sending it in order, with idle cycles of random length between bits. The only out-of-order bits it sends are stray nonzero indexes after an aborted or finished frame, and early restarts at index 0, both of which the block is required to handle.

// File: rtl/can_fp_pkg.sv
package can_fp_pkg;
  localparam int BID_W        = 11;
  localparam int EXT_W        = 18;
  localparam int ID_W         = BID_W + EXT_W;
  localparam int DLC_W        = 4;
  localparam int CRC_W        = 15;
  localparam int MAX_BYTES    = 8;
  // bit positions the decode depends on
  localparam int BID_END      = 11;
  localparam int SUB_POS      = 12;
  localparam int IDE_POS      = 13;
  localparam int BASE_DLC_END = 18;
  localparam int EXT_END      = 31;
  localparam int EXT_RTR_POS  = 32;
  localparam int EXT_DLC_END  = 38;
  // trailer offsets past the last data bit
  localparam int OFF_CRC_END  = CRC_W;
  localparam int OFF_CRC_DLM  = CRC_W + 1;
  localparam int OFF_ACK      = CRC_W + 2;
  localparam int OFF_ACK_DLM  = CRC_W + 3;
  localparam int OFF_EOF_BEG  = CRC_W + 4;
  localparam int OFF_EOF_END  = CRC_W + 10;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic             ide;
    logic             rtr;
    logic             srr;
    logic [DLC_W-1:0] dlc;
  } hdr_t;
endpackage

// File: rtl/can_fp_hdr.sv
module can_fp_hdr
  import can_fp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             stb_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  output hdr_t             hdr_o,
  output logic             hdr_stb_o,
  output logic             known_o,
  output logic [IDX_W-1:0] last_o
);
  logic [EXT_W-2:0] sh_q;
  logic [BID_W-1:0] bid_q;
  logic [EXT_W-1:0] ext_q;
  logic             b12_q, ide_q, rtr_q, known_q, hstb_q;
  logic [IDX_W-1:0] last_q;
  hdr_t             hdr_q;

  logic [IDX_W-1:0] dlc_end, n_bytes, last_new;
  logic [DLC_W-1:0] dlc_new;

  assign dlc_new = {sh_q[DLC_W-2:0], bit_i};
  assign dlc_end = ide_q ? IDX_W'(EXT_DLC_END) : IDX_W'(BASE_DLC_END);

  always_comb begin
    n_bytes = (dlc_new > DLC_W'(MAX_BYTES)) ? IDX_W'(MAX_BYTES) : IDX_W'(dlc_new);
    if (rtr_q) n_bytes = '0;  // remote: no data field
    last_new = dlc_end + (n_bytes << 3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; bid_q <= '0; ext_q <= '0;
      b12_q <= 1'b0; ide_q <= 1'b0; rtr_q <= 1'b0;
      known_q <= 1'b0; hstb_q <= 1'b0;
      last_q <= '0; hdr_q <= '0;
    end else begin
      hstb_q <= 1'b0;
      if (sof_i) begin
        known_q <= 1'b0;
        ide_q   <= 1'b0;
        rtr_q   <= 1'b0;
      end else if (stb_i && !known_q) begin
        sh_q <= {sh_q[EXT_W-3:0], bit_i};
        if (idx_i == IDX_W'(BID_END)) bid_q <= {sh_q[BID_W-2:0], bit_i};
        if (idx_i == IDX_W'(SUB_POS)) b12_q <= bit_i;
        if (idx_i == IDX_W'(IDE_POS)) begin
          ide_q <= bit_i;
          if (!bit_i) rtr_q <= b12_q;
        end
        if (ide_q && idx_i == IDX_W'(EXT_END))     ext_q <= {sh_q, bit_i};
        if (ide_q && idx_i == IDX_W'(EXT_RTR_POS)) rtr_q <= bit_i;
        if (idx_i == dlc_end) begin
          known_q   <= 1'b1;
          hstb_q    <= 1'b1;
          last_q    <= last_new;
          hdr_q.ide <= ide_q;
          hdr_q.rtr <= rtr_q;
          hdr_q.srr <= ide_q & b12_q;
          hdr_q.dlc <= dlc_new;
          hdr_q.id  <= ide_q ? {bid_q, ext_q} : ID_W'(bid_q);
        end
      end
    end
  end

  assign hdr_o     = hdr_q;
  assign hdr_stb_o = hstb_q;
  assign known_o   = known_q;
  assign last_o    = last_q;

  AST_HDR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_stb_o |=> !hdr_stb_o); // R5
endmodule

// File: rtl/can_fp_data.sv
module can_fp_data #(
  parameter int IDX_W = 8,
  parameter int BYTES = 8,
  localparam int BN_W = $clog2(BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             stb_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  input  logic             known_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [7:0]       byte_o,
  output logic             stb_o,
  output logic [BN_W-1:0]  num_o
);
  logic [6:0]      sh_q;
  logic [2:0]      cnt_q;
  logic [BN_W-1:0] nxt_q, num_q;
  logic [7:0]      byte_q;
  logic            bstb_q, in_data;

  assign in_data = stb_i && known_i && (idx_i <= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; cnt_q <= '0; nxt_q <= '0; num_q <= '0;
      byte_q <= '0; bstb_q <= 1'b0;
    end else begin
      bstb_q <= 1'b0;
      if (sof_i) begin
        cnt_q <= '0;
        nxt_q <= '0;
      end else if (in_data) begin
        sh_q  <= {sh_q[5:0], bit_i};
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          byte_q <= {sh_q, bit_i};
          bstb_q <= 1'b1;
          num_q  <= nxt_q;
          nxt_q  <= nxt_q + 1'b1;
        end
      end
    end
  end

  assign byte_o = byte_q;
  assign stb_o  = bstb_q;
  assign num_o  = num_q;

  AST_DATA_AFTER_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> known_i); // R6
endmodule

// File: rtl/can_fp_tail.sv
module can_fp_tail
  import can_fp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             stb_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  input  logic             known_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             crc_stb_o,
  output logic             ack_o,
  output logic             eof_o,
  output logic             err_o,
  output logic             kill_o
);
  logic [CRC_W-2:0] sh_q;
  logic [CRC_W-1:0] crc_q;
  logic             cstb_q, ack_q, eof_q, err_q, seen_q;
  logic [IDX_W-1:0] off;
  logic             in_tail, must_rec, bad, fin;

  assign off      = idx_i - last_i;
  assign in_tail  = stb_i && known_i && (idx_i > last_i);
  assign must_rec = (off == IDX_W'(OFF_CRC_DLM)) || (off == IDX_W'(OFF_ACK_DLM)) ||
                    ((off >= IDX_W'(OFF_EOF_BEG)) && (off <= IDX_W'(OFF_EOF_END)));
  assign bad      = in_tail && must_rec && !bit_i;
  assign fin      = in_tail && bit_i && (off == IDX_W'(OFF_EOF_END));
  assign kill_o   = bad || fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; crc_q <= '0; cstb_q <= 1'b0; ack_q <= 1'b0;
      eof_q <= 1'b0; err_q <= 1'b0; seen_q <= 1'b0;
    end else begin
      cstb_q <= 1'b0;
      eof_q  <= fin;
      err_q  <= bad;
      if (sof_i) begin
        seen_q <= 1'b0;
      end else if (in_tail) begin
        sh_q <= {sh_q[CRC_W-3:0], bit_i};
        if (off == IDX_W'(OFF_CRC_END)) begin
          crc_q  <= {sh_q, bit_i};
          cstb_q <= 1'b1;
          seen_q <= 1'b1;
        end
        if (off == IDX_W'(OFF_ACK)) ack_q <= !bit_i;
      end
    end
  end

  assign crc_o     = crc_q;
  assign crc_stb_o = cstb_q;
  assign ack_o     = ack_q;
  assign eof_o     = eof_q;
  assign err_o     = err_q;

  AST_EOF_NEEDS_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> seen_q); // R8
  AST_EOF_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eof_o && err_o)); // R10
endmodule

// File: rtl/can_field_parser.sv
module can_field_parser
  import can_fp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             bit_val_i,
  output logic             hdr_stb_o,
  output logic [28:0]      id_o,
  output logic             ide_o,
  output logic             rtr_o,
  output logic             srr_o,
  output logic [3:0]       dlc_o,
  output logic [7:0]       byte_o,
  output logic             byte_stb_o,
  output logic [2:0]       byte_num_o,
  output logic [14:0]      crc_o,
  output logic             crc_stb_o,
  output logic             ack_o,
  output logic             eof_o,
  output logic             form_err_o
);
  logic             act_q, sof_err_q;
  logic             sof_hit, stb, known, kill, tail_err;
  logic [IDX_W-1:0] last;
  hdr_t             hdr;

  assign sof_hit = bit_valid_i && (bit_idx_i == '0);
  assign stb     = bit_valid_i && act_q && (bit_idx_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      sof_err_q <= 1'b0;
    end else begin
      sof_err_q <= sof_hit && bit_val_i;
      if (sof_hit)          act_q <= !bit_val_i;
      else if (stb && kill) act_q <= 1'b0;
    end
  end

  can_fp_hdr #(.IDX_W(IDX_W)) u_hdr (
    .clk_i, .rst_ni, .sof_i(sof_hit), .stb_i(stb), .idx_i(bit_idx_i),
    .bit_i(bit_val_i), .hdr_o(hdr), .hdr_stb_o, .known_o(known), .last_o(last)
  );

  can_fp_data #(.IDX_W(IDX_W), .BYTES(MAX_BYTES)) u_data (
    .clk_i, .rst_ni, .sof_i(sof_hit), .stb_i(stb), .idx_i(bit_idx_i),
    .bit_i(bit_val_i), .known_i(known), .last_i(last),
    .byte_o, .stb_o(byte_stb_o), .num_o(byte_num_o)
  );

  can_fp_tail #(.IDX_W(IDX_W)) u_tail (
    .clk_i, .rst_ni, .sof_i(sof_hit), .stb_i(stb), .idx_i(bit_idx_i),
    .bit_i(bit_val_i), .known_i(known), .last_i(last),
    .crc_o, .crc_stb_o, .ack_o, .eof_o, .err_o(tail_err), .kill_o(kill)
  );

  assign id_o       = hdr.id;
  assign ide_o      = hdr.ide;
  assign rtr_o      = hdr.rtr;
  assign srr_o      = hdr.srr;
  assign dlc_o      = hdr.dlc;
  assign form_err_o = sof_err_q | tail_err;

  AST_SOF_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && bit_idx_i == '0 && bit_val_i) |=> form_err_o); // R1
  AST_REMOTE_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |-> !rtr_o); // R7
  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eof_o && form_err_o)); // R11
endmodule

// File: tb/sim_can_field_parser.sv
module sim_can_field_parser;
  localparam int IDX_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bit_valid_i = 1'b0;
  logic [IDX_W-1:0] bit_idx_i = '0;
  logic             bit_val_i = 1'b1;
  logic             hdr_stb_o, ide_o, rtr_o, srr_o, byte_stb_o, crc_stb_o, ack_o, eof_o, form_err_o;
  logic [28:0]      id_o;
  logic [3:0]       dlc_o;
  logic [7:0]       byte_o;
  logic [2:0]       byte_num_o;
  logic [14:0]      crc_o;

  always #10 clk = ~clk;  // 50 MHz

  can_field_parser #(.IDX_W(IDX_W)) u0 (
    .clk_i(clk), .rst_ni, .bit_valid_i, .bit_idx_i, .bit_val_i,
    .hdr_stb_o, .id_o, .ide_o, .rtr_o, .srr_o, .dlc_o, .byte_o, .byte_stb_o,
    .byte_num_o, .crc_o, .crc_stb_o, .ack_o, .eof_o, .form_err_o
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  int  q[$];
  int  fb[$];
  bit  m_act = 0, m_known = 0, m_ide = 0, m_rtr = 0;
  int  m_last = 0, m_de = 0;
  // expected outputs
  logic        e_hdr = 0, e_ide = 0, e_rtr = 0, e_srr = 0, e_bstb = 0, e_cstb = 0;
  logic        e_ack = 0, e_eof = 0, e_err = 0;
  logic [28:0] e_id = 0;
  logic [3:0]  e_dlc = 0;
  logic [7:0]  e_byte = 0;
  logic [2:0]  e_bnum = 0;
  logic [14:0] e_crc = 0;

  function automatic int fld(int s, int w);
    int v = 0;
    for (int i = 0; i < w; i++) v = (v << 1) | q[s + i];
    return v;
  endfunction

  task automatic model_step(bit v, int idx, bit b);
    int dlc, nb, off;
    e_hdr = 0; e_bstb = 0; e_cstb = 0; e_eof = 0; e_err = 0;
    if (!v) return;
    if (idx == 0) begin
      q.delete(); m_known = 0; m_ide = 0; m_rtr = 0;
      if (b) begin e_err = 1; m_act = 0; end
      else begin m_act = 1; q.push_back(0); end
      return;
    end
    if (!m_act) return;
    q.push_back(int'(b));
    if (!m_known) begin
      if (idx == 13) begin m_ide = b; if (!b) m_rtr = q[12][0]; end
      if (m_ide && idx == 32) m_rtr = b;
      m_de = m_ide ? 38 : 18;
      if (idx == m_de) begin
        dlc = fld(m_de - 3, 4);
        nb = m_rtr ? 0 : (dlc > 8 ? 8 : dlc);
        m_last = m_de + 8 * nb;
        e_hdr = 1; e_dlc = 4'(dlc); e_ide = m_ide; e_rtr = m_rtr;
        e_srr = m_ide ? q[12][0] : 1'b0;
        e_id = m_ide ? 29'((fld(1, 11) << 18) | fld(14, 18)) : 29'(fld(1, 11));
        m_known = 1;
      end
      return;
    end
    if (idx <= m_last) begin
      if ((idx - m_de) % 8 == 0) begin
        e_bstb = 1; e_byte = 8'(fld(idx - 7, 8)); e_bnum = 3'((idx - m_de) / 8 - 1);
      end
      return;
    end
    off = idx - m_last;
    if (off == 15) begin e_crc = 15'(fld(m_last + 1, 15)); e_cstb = 1; end
    if (off == 17) e_ack = !b;
    if (!b && (off == 16 || off == 18 || (off >= 19 && off <= 25))) begin
      e_err = 1; m_act = 0;
    end else if (off == 25) begin
      e_eof = 1; m_act = 0;
    end
  endtask

  task automatic chk(string tag, string nm, int act, int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, nm, act, exp, $time);
      bad = 1;
    end
  endtask

  task automatic compare();
    bit bad = 0;
    chk("R5", "hdr_stb", hdr_stb_o, e_hdr, bad);
    chk("R2/R4", "id", id_o, e_id, bad);
    chk("R3", "ide", ide_o, e_ide, bad);
    chk("R7", "rtr", rtr_o, e_rtr, bad);
    chk("R4", "srr", srr_o, e_srr, bad);
    chk("R5", "dlc", dlc_o, e_dlc, bad);
    chk("R6", "byte_stb", byte_stb_o, e_bstb, bad);
    if (e_bstb) begin
      chk("R6", "byte", byte_o, e_byte, bad);
      chk("R6", "byte_num", byte_num_o, e_bnum, bad);
    end
    chk("R8", "crc_stb", crc_stb_o, e_cstb, bad);
    if (e_cstb) chk("R8", "crc", crc_o, e_crc, bad);
    chk("R9", "ack", ack_o, e_ack, bad);
    chk("R10", "eof", eof_o, e_eof, bad);
    chk("R11/R1", "form_err", form_err_o, e_err, bad);
    n_cmp++;
    if (bad) n_bad++;
  endtask

  // one clock: check the result of the previous input, then drive the next (R12)
  task automatic step(bit v, int idx, bit b);
    @(negedge clk);
    compare();
    bit_valid_i = v; bit_idx_i = IDX_W'(idx); bit_val_i = b;
    model_step(v, idx, b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, int'($urandom % 128), bit'($urandom % 2));
  endtask

  task automatic pushv(int v, int w);
    for (int i = w - 1; i >= 0; i--) fb.push_back((v >> i) & 1);
  endtask

  task automatic build(bit ide, int id11, int ext18, bit b12, bit rtr, int dlc,
                       bit rsv, int seed, int crc, bit ackd);
    int nb;
    fb.delete();
    fb.push_back(0);
    pushv(id11, 11);
    if (!ide) begin
      pushv(rtr, 1); pushv(0, 1); pushv(rsv, 1);
    end else begin
      pushv(b12, 1); pushv(1, 1); pushv(ext18, 18); pushv(rtr, 1); pushv(rsv, 1); pushv(rsv, 1);
    end
    pushv(dlc, 4);
    nb = rtr ? 0 : (dlc > 8 ? 8 : dlc);
    for (int k = 0; k < nb; k++) pushv((seed + k * 37) & 8'hFF, 8);
    pushv(crc, 15);
    pushv(1, 1); pushv(ackd ? 0 : 1, 1); pushv(1, 1);
    pushv(7'h7F, 7);
  endtask

  task automatic send(int gapmax, int upto);
    int n = (upto < 0 || upto > fb.size()) ? fb.size() : upto;
    for (int i = 0; i < n; i++) begin
      if (gapmax > 0) idle(int'($urandom % (gapmax + 1)));
      step(1, i, fb[i][0]);
    end
  endtask

  initial begin
    #10000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL R12 watchdog expired: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(3);                                                       // R12 reset state
    build(0, 'h123, 0, 0, 0, 2, 0, 'hA5, 'h1ABC, 1); send(0, -1); // R2 R3 R6 R8 R9 R10
    idle(4);                                                       // R12 stray after EOF
    for (int i = 1; i < 5; i++) step(1, 40 + i, 0);
    build(1, 'h5A5, 'h2F0F1, 1, 0, 8, 0, 'h11, 'h7FFF, 1); send(3, -1); // R4 R6
    build(0, 'h7F0, 0, 0, 1, 4, 0, 0, 'h0001, 1); send(1, -1);    // R7 base remote
    build(1, 'h001, 'h3FFFF, 0, 1, 3, 0, 0, 'h4321, 0); send(2, -1); // R7 R4 remote, nack
    build(0, 'h2AA, 0, 0, 0, 15, 0, 'h5C, 'h2222, 1); send(0, -1); // R6 DLC>8 capped
    build(0, 'h055, 0, 0, 0, 0, 0, 0, 'h6666, 1); send(1, -1);     // R6 zero bytes
    step(1, 0, 1); step(1, 1, 0); step(1, 2, 1); idle(2);          // R1 recessive start
    build(0, 'h321, 0, 0, 0, 1, 0, 'h9E, 'h1111, 1);               // R11 CRC delimiter
    fb[19 + 8 + 15] = 0; send(0, -1); idle(2);
    build(1, 'h0F0, 'h0AAAA, 1, 0, 2, 0, 'h33, 'h0F0F, 1);         // R11 ACK delimiter
    fb[38 + 16 + 18] = 0; send(1, -1);
    build(0, 'h400, 0, 0, 0, 3, 0, 'h42, 'h5555, 0);               // R11 EOF bit
    fb[18 + 24 + 23] = 0; send(0, -1);
    build(0, 'h1FF, 0, 0, 0, 2, 1, 'hE1, 'h3003, 0); send(0, -1);  // R5 recessive reserved, R9 nack
    build(1, 'h3C3, 'h12345, 1, 0, 1, 1, 'h7E, 'h2A2A, 1); send(2, -1); // R5 ext reserved
    build(0, 'h111, 0, 0, 0, 5, 0, 'h08, 'h0808, 1); send(0, 30);  // R12 restart mid-frame
    build(0, 'h222, 0, 0, 0, 1, 0, 'hC7, 'h7007, 1); send(0, -1);
    idle(3);
    step(0, 0, 1);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule